// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block holds the protection fields of a serial flash status register and judges every program and erase request against them. It takes command strobes that are already decoded: write-status, program, sector erase, chip erase, suspend and resume. It also takes a 22-bit target address, the level of the write-protect pin and an active-low power-up reset. The array is split into 64 blocks of 64 KB. A 4-bit protect code selects a protected window of blocks. The window grows from the top of the array, grows from the bottom, covers every block, or covers none.

A lock bit freezes itself and the protect code, but only while the write-protect pin is effectively low. When the quad-enable bit is set, the pin serves as a data line and counts as high. A read-only suspend flag is set by a suspend command and cleared by a resume command or by reset. Each program or erase request gets a registered verdict one cycle later: a grant pulse, or a protection-error pulse. The current fields are always visible as one status byte.

Top module: `sfp_wprot`

## Requirements
- R1: After reset the status byte reads 0x00, and neither grant nor prot_err is asserted.
- R2: Protect codes 1 to 6 protect the top 1, 2, 4, 8, 16 and 32 blocks in that order. Code 1 covers 0x3F0000 to 0x3FFFFF and code 6 covers 0x200000 to 0x3FFFFF.
- R3: Code 0 protects no block. Codes 7, 8 and 15 protect all 64 blocks.
- R4: Codes 9 to 14 protect the bottom 32, 48, 56, 60, 62 and 63 blocks in that order. Code 9 covers 0x000000 to 0x1FFFFF and code 14 covers 0x000000 to 0x3EFFFF.
- R5: For a program or sector-erase strobe, exactly one of grant and prot_err pulses for a single cycle, in the cycle after the strobe. prot_err is the one that pulses when the address lies in a protected block. Neither output pulses without a request.
- R6: A chip-erase strobe is granted only when the protect code is 0. Otherwise it raises prot_err.
- R7: While the write-protect pin is effectively low and the lock bit is 1, a write-status command leaves the lock bit and the protect code unchanged.
- R8: While the write-protect pin is high, a write-status command writes the lock bit and the protect code from its data, whatever the lock bit holds.
- R9: The quad-enable bit is always writable. While it is 1, the write-protect pin counts as high for the lock check.
- R10: The suspend flag is set by a suspend strobe and cleared by a resume strobe or by reset. Resume wins when both strobes arrive together. A write-status command never changes the flag.
- R11: Status byte layout: bit 7 lock, bit 6 quad-enable, bits 5..2 protect code (bit 5 is its MSB), bit 1 suspend, bit 0 always 0. Write-status data uses the same positions for bits 7..2; its bits 1 and 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset, asynchronous |
| wrsr_stb | input | 1 | Write-status command strobe |
| wrsr_data | input | 8 | Data for the write-status command |
| prog_stb | input | 1 | Program request strobe |
| serase_stb | input | 1 | Sector-erase request strobe |
| cerase_stb | input | 1 | Chip-erase request strobe |
| susp_stb | input | 1 | Suspend command strobe |
| resm_stb | input | 1 | Resume command strobe |
| addr | input | 22 | Target byte address of the request |
| wp_pin | input | 1 | Write-protect pin level (1 = high) |
| grant | output | 1 | Request accepted, one cycle after the strobe |
| prot_err | output | 1 | Request refused, one cycle after the strobe |
| status | output | 8 | Status byte |

## Verification
The checker watches every cycle for several rules. The two verdicts must be mutually exclusive and must always answer a request. A chip erase must be refused under a non-zero code. The frozen fields must stay put when a write-status arrives during lock-down. The suspend flag must follow its strobes, and status bit 0 must read zero. The exact block window for each of the sixteen codes can only be shown by the bench. It sweeps every code across the window boundaries and compares the verdicts against its own address table. The bench also runs the lock and quad-enable sequences and the reset-clears-all sequence.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

  typedef struct packed {
    logic       lock;
    logic       qe;
    logic [3:0] code;
    logic       susp;
  } sfp_fields_t;

  // Does protect code 'code' cover block 'blk' of an array of 2**blk_w blocks?
  function automatic logic blk_protected(input logic [3:0] code,
                                         input int unsigned blk,
                                         input int unsigned blk_w);
    int unsigned nblk;
    int unsigned span;
    logic        r;
    nblk = 32'd1 << blk_w;
    r    = 1'b0;
    case (code)
      4'd0:                r = 1'b0;
      4'd7, 4'd8, 4'd15:   r = 1'b1;
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6: begin
        span = nblk >> (7 - int'(code));
        r    = (blk >= nblk - span);
      end
      default: begin
        span = nblk >> (int'(code) - 8);
        r    = (blk < nblk - span);
      end
    endcase
    return r;
  endfunction

  function automatic logic [7:0] pack_status(input sfp_fields_t f);
    return {f.lock, f.qe, f.code, f.susp, 1'b0};
  endfunction

endpackage

// File: rtl/sfp_status_reg.sv
module sfp_status_reg
  import sfp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrsr_stb,
  input  logic [7:0]  wrsr_data,
  input  logic        susp_stb,
  input  logic        resm_stb,
  input  logic        wp_pin,
  output sfp_fields_t fields,
  output logic        frozen
);

  logic wp_eff_high;

  // Quad mode lends the pin to data, so it counts as high.
  assign wp_eff_high = wp_pin | fields.qe;
  assign frozen      = fields.lock & ~wp_eff_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields <= '0;
    end else begin
      if (wrsr_stb) begin
        fields.qe <= wrsr_data[6];
        if (!frozen) begin
          fields.lock <= wrsr_data[7];
          fields.code <= wrsr_data[5:2];
        end
      end
      if (resm_stb)      fields.susp <= 1'b0;
      else if (susp_stb) fields.susp <= 1'b1;
    end
  end

endmodule

// File: rtl/sfp_range_chk.sv
module sfp_range_chk
  import sfp_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int BLOCK_AW = 16
) (
  input  logic [3:0]        code,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              code_zero
);

  localparam int BLK_W = ADDR_W - BLOCK_AW;
  localparam int NBLK  = 1 << BLK_W;

  logic [NBLK-1:0]  prot_mask;
  logic [BLK_W-1:0] blk_idx;

  assign blk_idx = addr[ADDR_W-1:BLOCK_AW];

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    assign prot_mask[b] = blk_protected(code, b, BLK_W);
  end

  assign hit       = prot_mask[blk_idx];
  assign code_zero = (code == 4'd0);

endmodule

// File: rtl/sfp_req_resp.sv
module sfp_req_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_stb,
  input  logic serase_stb,
  input  logic cerase_stb,
  input  logic hit,
  input  logic code_zero,
  output logic req_any,
  output logic allow,
  output logic grant,
  output logic prot_err
);

  assign req_any = prog_stb | serase_stb | cerase_stb;
  // Chip erase rule takes precedence when strobes overlap.
  assign allow   = cerase_stb ? code_zero : ~hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant    <= 1'b0;
      prot_err <= 1'b0;
    end else begin
      grant    <= req_any & allow;
      prot_err <= req_any & ~allow;
    end
  end

endmodule

// File: rtl/sfp_wprot.sv
module sfp_wprot
  import sfp_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int BLOCK_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrsr_stb,
  input  logic [7:0]        wrsr_data,
  input  logic              prog_stb,
  input  logic              serase_stb,
  input  logic              cerase_stb,
  input  logic              susp_stb,
  input  logic              resm_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wp_pin,
  output logic              grant,
  output logic              prot_err,
  output logic [7:0]        status
);

  sfp_fields_t fields;
  logic        bp_frozen;
  logic        range_hit;
  logic        code_zero;
  logic        req_any;
  logic        req_allow;

  sfp_status_reg u_sreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrsr_stb  (wrsr_stb),
    .wrsr_data (wrsr_data),
    .susp_stb  (susp_stb),
    .resm_stb  (resm_stb),
    .wp_pin    (wp_pin),
    .fields    (fields),
    .frozen    (bp_frozen)
  );

  sfp_range_chk #(.ADDR_W(ADDR_W), .BLOCK_AW(BLOCK_AW)) u_range (
    .code      (fields.code),
    .addr      (addr),
    .hit       (range_hit),
    .code_zero (code_zero)
  );

  sfp_req_resp u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_stb   (prog_stb),
    .serase_stb (serase_stb),
    .cerase_stb (cerase_stb),
    .hit        (range_hit),
    .code_zero  (code_zero),
    .req_any    (req_any),
    .allow      (req_allow),
    .grant      (grant),
    .prot_err   (prot_err)
  );

  assign status = pack_status(fields);

endmodule

// File: rtl/sfp_wprot_chk.sv
module sfp_wprot_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wrsr_stb,
  input logic       prog_stb,
  input logic       serase_stb,
  input logic       cerase_stb,
  input logic       susp_stb,
  input logic       resm_stb,
  input logic       grant,
  input logic       prot_err,
  input logic [7:0] status,
  input logic       bp_frozen
);

  logic req;
  assign req = prog_stb | serase_stb | cerase_stb;

  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && prot_err));

  a_r5_answered: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (grant || prot_err));

  a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (!grant && !prot_err));

  a_r6_cerase_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (cerase_stb && status[5:2] != 4'd0) |=> (prot_err && !grant));

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_stb && bp_frozen) |=> ($stable(status[7]) && $stable(status[5:2])));

  a_r10_set: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_stb && !resm_stb) |=> status[1]);

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    resm_stb |=> !status[1]);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!susp_stb && !resm_stb) |=> $stable(status[1]));

  a_r11_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] == 1'b0);

endmodule

bind sfp_wprot sfp_wprot_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wrsr_stb   (wrsr_stb),
  .prog_stb   (prog_stb),
  .serase_stb (serase_stb),
  .cerase_stb (cerase_stb),
  .susp_stb   (susp_stb),
  .resm_stb   (resm_stb),
  .grant      (grant),
  .prot_err   (prot_err),
  .status     (status),
  .bp_frozen  (bp_frozen)
);

// File: tb/sfp_wprot_bench.sv
module sfp_wprot_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrsr_stb = 1'b0;
  logic [7:0]  wrsr_data = '0;
  logic        prog_stb = 1'b0, serase_stb = 1'b0, cerase_stb = 1'b0;
  logic        susp_stb = 1'b0, resm_stb = 1'b0;
  logic [21:0] addr = '0;
  logic        wp_pin = 1'b1;
  logic        grant, prot_err;
  logic [7:0]  status;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  bit    q_ok[$];
  string q_tag[$];

  always #10 clk = ~clk;  // 50 MHz

  sfp_wprot u_sfp_wprot (
    .clk(clk), .rst_n(rst_n), .wrsr_stb(wrsr_stb), .wrsr_data(wrsr_data),
    .prog_stb(prog_stb), .serase_stb(serase_stb), .cerase_stb(cerase_stb),
    .susp_stb(susp_stb), .resm_stb(resm_stb), .addr(addr), .wp_pin(wp_pin),
    .grant(grant), .prot_err(prot_err), .status(status)
  );

  // Expected window per code, written as address bounds.
  function automatic bit exp_locked(input logic [3:0] c, input logic [21:0] a);
    logic [21:0] lo, hi;
    bit none;
    none = 0; lo = 22'h000000; hi = 22'h3FFFFF;
    case (c)
      4'h0: none = 1;
      4'h1: lo = 22'h3F0000;
      4'h2: lo = 22'h3E0000;
      4'h3: lo = 22'h3C0000;
      4'h4: lo = 22'h380000;
      4'h5: lo = 22'h300000;
      4'h6: lo = 22'h200000;
      4'h9: hi = 22'h1FFFFF;
      4'hA: hi = 22'h2FFFFF;
      4'hB: hi = 22'h37FFFF;
      4'hC: hi = 22'h3BFFFF;
      4'hD: hi = 22'h3DFFFF;
      4'hE: hi = 22'h3EFFFF;
      default: ;
    endcase
    return !none && a >= lo && a <= hi;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // kind: 0 program, 1 sector erase, 2 chip erase
  task automatic request(input int kind, input logic [21:0] a, input bit ok, input string tag);
    @(negedge clk);
    addr = a;
    prog_stb   = (kind == 0);
    serase_stb = (kind == 1);
    cerase_stb = (kind == 2);
    q_ok.push_back(ok);
    q_tag.push_back(tag);
    @(negedge clk);
    prog_stb = 0; serase_stb = 0; cerase_stb = 0;
  endtask

  task automatic write_sr(input logic [7:0] d);
    @(negedge clk);
    wrsr_stb = 1; wrsr_data = d;
    @(negedge clk);
    wrsr_stb = 0;
  endtask

  task automatic pulse_cmd(input bit s, input bit r);
    @(negedge clk);
    susp_stb = s; resm_stb = r;
    @(negedge clk);
    susp_stb = 0; resm_stb = 0;
  endtask

  // Monitor: scoreboard comparison of verdicts.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n) begin
        if (q_ok.size() > 0) begin
          bit    ok;
          string tg;
          ok = q_ok.pop_front();
          tg = q_tag.pop_front();
          chk(tg, {6'd0, grant, prot_err}, {6'd0, ok, !ok});
        end else if (grant || prot_err) begin
          n_cmp++; n_bad++;
          $display("FAIL R5 unrequested verdict: actual=%b%b expected=00", grant, prot_err);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [21:0] pts[14];
    pts = '{22'h000000, 22'h1FFFFF, 22'h200000, 22'h2FFFFF, 22'h300000,
            22'h37FFFF, 22'h380000, 22'h3BFFFF, 22'h3C0000, 22'h3DFFFF,
            22'h3E0000, 22'h3EFFFF, 22'h3F0000, 22'h3FFFFF};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", status, 8'h00);
    chk("R1 verdicts", {6'd0, grant, prot_err}, 8'h00);

    // R2 R3 R4 R5 R6: sweep every code, wp high
    for (int c = 0; c < 16; c++) begin
      string tg;
      write_sr({2'b00, c[3:0], 2'b00});
      chk("R8 R11 code written", status, {2'b00, c[3:0], 2'b00});
      if (c >= 1 && c <= 6)                 tg = "R2 R5";
      else if (c == 0 || c == 7 || c == 8 || c == 15) tg = "R3 R5";
      else                                  tg = "R4 R5";
      for (int i = 0; i < 14; i++)
        request(i % 2, pts[i], !exp_locked(c[3:0], pts[i]), tg);
      request(2, 22'h123456, (c == 0), "R6 chip erase");
    end
    repeat (3) @(negedge clk);

    // R7 lock-down with wp low
    write_sr(8'h00);
    wp_pin = 0;
    write_sr(8'h8C);
    chk("R7 lock set while unlocked", status, 8'h8C);
    write_sr(8'h00);
    chk("R7 frozen", status, 8'h8C);
    request(0, 22'h3FFFFF, 0, "R7 still protected");
    // R8 wp high: lock has no effect
    wp_pin = 1;
    write_sr(8'h84);
    chk("R8 written under lock", status, 8'h84);
    // R9 quad enable writable while frozen, then pin counts as high
    wp_pin = 0;
    write_sr(8'hC0);
    chk("R9 qe written, code frozen", status, 8'hC4);
    write_sr(8'h40);
    chk("R9 qe lifts freeze", status, 8'h40);
    write_sr(8'h00);
    chk("R9 cleared", status, 8'h00);
    wp_pin = 1;

    // R10 suspend flag
    pulse_cmd(1, 0);
    chk("R10 suspend sets", status, 8'h02);
    write_sr(8'h00);
    chk("R10 wrsr cannot clear", status, 8'h02);
    pulse_cmd(0, 1);
    chk("R10 resume clears", status, 8'h00);
    write_sr(8'h03);
    chk("R10 R11 wrsr low bits ignored", status, 8'h00);
    pulse_cmd(1, 0);
    pulse_cmd(1, 1);
    chk("R10 resume wins", status, 8'h00);

    // R1 reset clears everything
    pulse_cmd(1, 0);
    write_sr(8'hDC);
    chk("R11 layout", status, 8'hDE);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R1 reset clears", status, 8'h00);
    rst_n = 1;
    request(2, 22'h0, 1, "R1 R6 chip erase after reset");
    repeat (4) @(negedge clk);
    chk("R5 queue drained", 8'(q_ok.size()), 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule